// File: doc/BRIEF.md
# Sleep and Wake Power Controller

This block is the always-on power controller of a chip. It stays powered while the rest of the chip is switched off. Software reaches it over a simple synchronous register bus. Writes honour per-byte lane enables. Reads are combinational in the cycle of the access.

To put the chip to sleep, software does three things. It sets an enable for each wake pin that may wake the chip. It stores a resume address in one of two retained scratch words. It then writes the control register with a sleep depth and the force bit set. The controller asserts a power-down request for a fixed number of cycles and then drops the main power request. After that it waits for a rising edge on an enabled wake pin. When one arrives, the controller raises power again. It passes through a short wake phase and returns to the active state. A sticky cause flag records which pin woke the chip.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, `pwrOnOut` is 1, `pdnReqOut` is 0 and `deepSleepOut` is 0. Every register reads 0, including the state code.
- R2: The register map is as follows. Offset 0x08 holds the wake enables in bits [NUM_WAKE-1:0], with bit k enabling wake pin k. Offsets 0x18 and 0x1C are full-width scratch words. Any other offset reads 0. A write changes only the byte lanes whose `beIn` bit is set.
- R3: Writing 1 to bit 0 (the force bit) of the control register at offset 0x00 while active starts sleep entry. `pdnReqOut` is then held for exactly ENTER_CYCLES cycles with `pwrOnOut` still 1. After that, `pwrOnOut` drops to 0.
- R4: The force bit clears itself when sleep is reached. It reads 0 during sleep and after wake. After wake, no further sleep entry follows unless software writes the bit again.
- R5: The chip leaves sleep only on a rising edge of a synchronized wake pin whose enable bit is set. An edge on a disabled pin does not wake it. Neither does a pin held steadily high.
- R6: The read-only state code at offset 0x04 bits [1:0] encodes the states as active=0, entering=1, asleep=2, waking=3. Writes to offset 0x04 have no effect. `pwrOnOut` returns to 1 at the third rising clock edge after an enabled pin rises. The state then reads 3 for exactly WAKE_CYCLES cycles and 0 after that.
- R7: At offset 0x14, bits [NUM_WAKE-1:0] show the synchronized pin levels. Bits [8+NUM_WAKE-1:8] hold sticky flags for the pins that caused the last wake. A flag is cleared by writing 1 to it with `beIn[1]` set. Writing 0 leaves it unchanged.
- R8: Control bits [2:1] hold the sleep mode. The mode is captured at the start of entry. `deepSleepOut` is 1 during sleep only if the captured mode was 1. Any other mode gives light sleep, with `deepSleepOut` at 0 and the same wake rules. Writing the mode during sleep does not change `deepSleepOut`.
- R9: Both scratch words keep their contents across a sleep and wake cycle.
- R10: A write of the force bit while not active is ignored. In the same write, the mode field still takes the written value.
- R11: A rising edge on an enabled pin while active sets no cause flag and does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 1 | Bus access strobe |
| wrIn | input | 1 | 1 for write, 0 for read |
| addrIn | input | ADDR_W | Byte offset of the register |
| beIn | input | DATA_W/8 | Write byte-lane enables |
| wdataIn | input | DATA_W | Write data |
| rdataOut | output | DATA_W | Read data, valid in the access cycle |
| wakePinIn | input | NUM_WAKE | Asynchronous wake pins, bit 0 is the on-key |
| pwrOnOut | output | 1 | Main power request |
| pdnReqOut | output | 1 | Power-down request during sleep entry |
| deepSleepOut | output | 1 | Asleep in deep mode |

## Verification
Some properties are checked on every cycle. The power-down request only appears while power is still on. Power only falls directly after a request. The force bit is never set while asleep. A wake is always preceded by an enabled pin edge. The deep indication only appears with power off and holds steady through a sleep. Other behaviour can only be shown by the directed scenarios. These cover the exact entry and wake cycle counts and the decoding of each offset with byte lanes. They also cover the write-one-to-clear cause flags, the retention of the scratch words, and the rejection of disabled, static or active-time pin edges.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ENTER  = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_WAKE   = 2'd3
  } pwr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       forceWrEn;
    logic       clrForce;
    logic       latchMode;
    logic       setCause;
    logic       asleep;
    pwr_state_e state;
  } ctl_strb_t;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_PWR    = 8'h04;
  localparam logic [7:0] OFF_TRIG   = 8'h08;
  localparam logic [7:0] OFF_PINS   = 8'h14;
  localparam logic [7:0] OFF_SCR_A  = 8'h18;
  localparam logic [7:0] OFF_SCR_B  = 8'h1C;

  localparam logic [1:0] MODE_DEEP  = 2'd1;
  localparam int         CAUSE_LSB  = 8;

endpackage

// File: rtl/sleep_ctrl_dp.sv
module sleep_ctrl_dp
  import sleep_ctrl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_WAKE = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  selIn,
  input  logic                  wrIn,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [DATA_W/8-1:0]   beIn,
  input  logic [DATA_W-1:0]     wdataIn,
  output logic [DATA_W-1:0]     rdataOut,
  input  logic [NUM_WAKE-1:0]   wakePinIn,
  input  ctl_strb_t             strb,
  output logic                  forceBit,
  output logic                  wakeHit,
  output logic                  deepSleepOut
);

  localparam int NUM_LANES = DATA_W / 8;

  logic                hitCtrl, hitPwr, hitTrig, hitPins, hitScrA, hitScrB;
  logic                wrAcc;
  logic [1:0]          modeReg;
  logic                deepLatched;
  logic [NUM_WAKE-1:0] trigEn;
  logic [NUM_WAKE-1:0] pinSync1, pinSync2, pinPrev, pinRise;
  logic [NUM_WAKE-1:0] causeReg, causeSet, causeClr;
  logic [DATA_W-1:0]   scratchA, scratchB;

  assign hitCtrl = (addrIn == ADDR_W'(OFF_CTRL));
  assign hitPwr  = (addrIn == ADDR_W'(OFF_PWR));
  assign hitTrig = (addrIn == ADDR_W'(OFF_TRIG));
  assign hitPins = (addrIn == ADDR_W'(OFF_PINS));
  assign hitScrA = (addrIn == ADDR_W'(OFF_SCR_A));
  assign hitScrB = (addrIn == ADDR_W'(OFF_SCR_B));
  assign wrAcc   = selIn && wrIn;

  // control register: force bit and mode field
  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceBit <= 1'b0;
      modeReg  <= 2'd0;
    end else begin
      if (wrAcc && hitCtrl && beIn[0]) begin
        modeReg <= wdataIn[2:1];
        if (strb.forceWrEn) forceBit <= wdataIn[0];
      end
      if (strb.clrForce) forceBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               deepLatched <= 1'b0;
    else if (strb.latchMode) deepLatched <= (modeReg == MODE_DEEP);
  end

  assign deepSleepOut = strb.asleep && deepLatched;

  always_ff @(posedge clk) begin
    if (!rstN)                           trigEn <= '0;
    else if (wrAcc && hitTrig && beIn[0]) trigEn <= wdataIn[NUM_WAKE-1:0];
  end

  // two-flop synchronizer then rising-edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinSync1 <= '0;
      pinSync2 <= '0;
      pinPrev  <= '0;
    end else begin
      pinSync1 <= wakePinIn;
      pinSync2 <= pinSync1;
      pinPrev  <= pinSync2;
    end
  end

  assign pinRise  = pinSync2 & ~pinPrev;
  assign wakeHit  = |(pinRise & trigEn);
  assign causeSet = strb.setCause ? (pinRise & trigEn) : '0;
  assign causeClr = (wrAcc && hitPins && beIn[1]) ?
                    wdataIn[CAUSE_LSB +: NUM_WAKE] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) causeReg <= '0;
    else       causeReg <= (causeReg & ~causeClr) | causeSet;
  end

  // retained scratch words, one byte lane each
  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        scratchA[lane*8 +: 8] <= 8'd0;
        scratchB[lane*8 +: 8] <= 8'd0;
      end else begin
        if (wrAcc && hitScrA && beIn[lane]) scratchA[lane*8 +: 8] <= wdataIn[lane*8 +: 8];
        if (wrAcc && hitScrB && beIn[lane]) scratchB[lane*8 +: 8] <= wdataIn[lane*8 +: 8];
      end
    end
  end

  always_comb begin
    rdataOut = '0;
    if (selIn && !wrIn) begin
      if (hitCtrl) begin
        rdataOut[0]   = forceBit;
        rdataOut[2:1] = modeReg;
      end
      if (hitPwr)  rdataOut[1:0] = strb.state;
      if (hitTrig) rdataOut[NUM_WAKE-1:0] = trigEn;
      if (hitPins) begin
        rdataOut[NUM_WAKE-1:0]           = pinSync2;
        rdataOut[CAUSE_LSB +: NUM_WAKE]  = causeReg;
      end
      if (hitScrA) rdataOut = scratchA;
      if (hitScrB) rdataOut = scratchB;
    end
  end

endmodule

// File: rtl/sleep_ctrl_fsm.sv
module sleep_ctrl_fsm
  import sleep_ctrl_pkg::*;
#(
  parameter int ENTER_CYCLES = 4,
  parameter int WAKE_CYCLES  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      forceBit,
  input  logic      wakeHit,
  output ctl_strb_t strb,
  output logic      pwrOnOut,
  output logic      pdnReqOut
);

  localparam int MAX_CYC = (ENTER_CYCLES > WAKE_CYCLES) ? ENTER_CYCLES : WAKE_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  pwr_state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ;
  logic enterDone, wakeDone;

  assign enterDone = (cntQ == CNT_W'(ENTER_CYCLES - 1));
  assign wakeDone  = (cntQ == CNT_W'(WAKE_CYCLES - 1));

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_ACTIVE: if (forceBit)  stateD = ST_ENTER;
      ST_ENTER:  if (enterDone) stateD = ST_SLEEP;
      ST_SLEEP:  if (wakeHit)   stateD = ST_WAKE;
      ST_WAKE:   if (wakeDone)  stateD = ST_ACTIVE;
      default:                  stateD = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_ACTIVE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (stateD != stateQ) cntQ <= '0;
      else                  cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    strb.forceWrEn = (stateQ == ST_ACTIVE);
    strb.clrForce  = (stateQ == ST_ENTER) && enterDone;
    strb.latchMode = (stateQ == ST_ACTIVE) && forceBit;
    strb.setCause  = (stateQ == ST_SLEEP) && wakeHit;
    strb.asleep    = (stateQ == ST_SLEEP);
    strb.state     = stateQ;
  end

  assign pwrOnOut  = (stateQ != ST_SLEEP);
  assign pdnReqOut = (stateQ == ST_ENTER);

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int NUM_WAKE     = 4,
  parameter int ENTER_CYCLES = 4,
  parameter int WAKE_CYCLES  = 4
) (
  input  logic                clkIn,
  input  logic                rstN,
  input  logic                selIn,
  input  logic                wrIn,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W/8-1:0] beIn,
  input  logic [DATA_W-1:0]   wdataIn,
  output logic [DATA_W-1:0]   rdataOut,
  input  logic [NUM_WAKE-1:0] wakePinIn,
  output logic                pwrOnOut,
  output logic                pdnReqOut,
  output logic                deepSleepOut
);

  ctl_strb_t ctlStrb;
  logic      forceBit;
  logic      wakeHit;

  sleep_ctrl_fsm #(
    .ENTER_CYCLES(ENTER_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_fsm (
    .clk      (clkIn),
    .rstN     (rstN),
    .forceBit (forceBit),
    .wakeHit  (wakeHit),
    .strb     (ctlStrb),
    .pwrOnOut (pwrOnOut),
    .pdnReqOut(pdnReqOut)
  );

  sleep_ctrl_dp #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_WAKE(NUM_WAKE)
  ) u_dp (
    .clk         (clkIn),
    .rstN        (rstN),
    .selIn       (selIn),
    .wrIn        (wrIn),
    .addrIn      (addrIn),
    .beIn        (beIn),
    .wdataIn     (wdataIn),
    .rdataOut    (rdataOut),
    .wakePinIn   (wakePinIn),
    .strb        (ctlStrb),
    .forceBit    (forceBit),
    .wakeHit     (wakeHit),
    .deepSleepOut(deepSleepOut)
  );

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwrOnOut,
  input logic       pdnReqOut,
  input logic       deepSleepOut,
  input logic [1:0] stateCode,
  input logic       forceBit,
  input logic       wakeHit
);

  assert_pdn_with_power_R3: assert property (@(posedge clk) disable iff (!rstN)
    pdnReqOut |-> pwrOnOut);

  assert_off_after_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrOnOut) |-> $past(pdnReqOut));

  assert_force_clear_asleep_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'd2) |-> !forceBit);

  assert_wake_needs_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((stateCode == 2'd3) && ($past(stateCode) == 2'd2)) |-> $past(wakeHit));

  assert_deep_only_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    deepSleepOut |-> !pwrOnOut);

  assert_deep_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrOnOut && $past(!pwrOnOut)) |-> $stable(deepSleepOut));

endmodule

bind sleep_ctrl sleep_ctrl_chk u_chk (
  .clk         (clkIn),
  .rstN        (rstN),
  .pwrOnOut    (pwrOnOut),
  .pdnReqOut   (pdnReqOut),
  .deepSleepOut(deepSleepOut),
  .stateCode   (ctlStrb.state),
  .forceBit    (forceBit),
  .wakeHit     (wakeHit)
);

// File: tb/sleep_ctrl_tb.sv
module sleep_ctrl_tb;

  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 8;
  localparam int NUM_WAKE     = 4;
  localparam int ENTER_CYCLES = 4;
  localparam int WAKE_CYCLES  = 4;

  logic                clkIn = 1'b0;
  logic                rstN  = 1'b0;
  logic                selIn = 1'b0;
  logic                wrIn  = 1'b0;
  logic [ADDR_W-1:0]   addrIn = '0;
  logic [DATA_W/8-1:0] beIn = '0;
  logic [DATA_W-1:0]   wdataIn = '0;
  logic [DATA_W-1:0]   rdataOut;
  logic [NUM_WAKE-1:0] wakePinIn = '0;
  logic                pwrOnOut, pdnReqOut, deepSleepOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clkIn = ~clkIn;

  sleep_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WAKE(NUM_WAKE),
    .ENTER_CYCLES(ENTER_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_dut (
    .clkIn(clkIn), .rstN(rstN), .selIn(selIn), .wrIn(wrIn), .addrIn(addrIn),
    .beIn(beIn), .wdataIn(wdataIn), .rdataOut(rdataOut), .wakePinIn(wakePinIn),
    .pwrOnOut(pwrOnOut), .pdnReqOut(pdnReqOut), .deepSleepOut(deepSleepOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clkIn);
    selIn = 1'b1; wrIn = 1'b1; addrIn = a; wdataIn = d; beIn = be;
    @(negedge clkIn);
    selIn = 1'b0; wrIn = 1'b0; beIn = '0;
  endtask

  // caller is positioned just after a falling edge
  task automatic rdNow(input logic [7:0] a, output logic [31:0] d);
    selIn = 1'b1; wrIn = 1'b0; addrIn = a;
    #1;
    d = rdataOut;
    selIn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clkIn);
    rdNow(a, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clkIn);
  endtask

  task automatic waitOff(output int pdnCnt);
    pdnCnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clkIn);
      if (pdnReqOut) begin
        pdnCnt++;
        if (!pwrOnOut) pdnCnt = 100;
      end
      if (!pwrOnOut) break;
    end
  endtask

  task automatic test_reset();
    logic [31:0] d;
    chk("R1 pwrOn", 32'(pwrOnOut), 32'd1);
    chk("R1 pdnReq", 32'(pdnReqOut), 32'd0);
    chk("R1 deep", 32'(deepSleepOut), 32'd0);
    rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h04, d); chk("R1 state", d, 32'h0);
    rd(8'h08, d); chk("R1 trig", d, 32'h0);
    rd(8'h14, d); chk("R1 pins", d, 32'h0);
    rd(8'h18, d); chk("R1 scratchA", d, 32'h0);
  endtask

  task automatic test_regs();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF, 4'b0001);
    rd(8'h08, d); chk("R2 trig enables", d, 32'h0000_000F);
    wr(8'h18, 32'hA5A5_1234, 4'b1111);
    wr(8'h18, 32'hFFFF_FFFF, 4'b0100);
    rd(8'h18, d); chk("R2 byte lane", d, 32'hA5FF_1234);
    rd(8'h10, d); chk("R2 unmapped", d, 32'h0);
    wr(8'h04, 32'h3, 4'b1111);
    rd(8'h04, d); chk("R6 state read-only", d, 32'h0);
    wr(8'h08, 32'h0, 4'b0001);
  endtask

  task automatic test_enter_deep();
    logic [31:0] d;
    int n;
    wr(8'h08, 32'h1, 4'b0001);
    wr(8'h18, 32'h8000_1000, 4'b1111);
    wr(8'h1C, 32'hCAFE_F00D, 4'b1111);
    wr(8'h00, 32'h3, 4'b0001);
    waitOff(n);
    chk("R3 pdn request cycles", 32'(n), 32'(ENTER_CYCLES));
    chk("R3 power dropped", 32'(pwrOnOut), 32'd0);
    chk("R8 deep sleep", 32'(deepSleepOut), 32'd1);
    rd(8'h00, d); chk("R4 force cleared asleep", d, 32'h2);
    rd(8'h04, d); chk("R6 state asleep", d, 32'h2);
  endtask

  task automatic test_disabled_pin();
    wakePinIn[1] = 1'b1;
    idle(8);
    chk("R5 disabled pin ignored", 32'(pwrOnOut), 32'd0);
    wakePinIn[1] = 1'b0;
    idle(4);
  endtask

  task automatic test_force_in_sleep();
    logic [31:0] d;
    wr(8'h00, 32'h1, 4'b0001);
    rd(8'h00, d); chk("R10 force ignored, mode written", d, 32'h0);
    chk("R8 deep unchanged by mode write", 32'(deepSleepOut), 32'd1);
  endtask

  task automatic test_wake();
    logic [31:0] d;
    int n;
    int w;
    @(negedge clkIn);
    wakePinIn[0] = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clkIn);
      n++;
      if (pwrOnOut) break;
    end
    chk("R6 wake latency", 32'(n), 32'd3);
    rdNow(8'h04, d);
    w = 0;
    while (d == 32'h3 && w < 50) begin
      w++;
      rd(8'h04, d);
    end
    chk("R6 wake phase length", 32'(w), 32'(WAKE_CYCLES));
    chk("R6 back to active", d, 32'h0);
    rd(8'h14, d); chk("R7 level and cause", d, 32'h0000_0101);
    rd(8'h18, d); chk("R9 scratchA kept", d, 32'h8000_1000);
    rd(8'h1C, d); chk("R9 scratchB kept", d, 32'hCAFE_F00D);
    rd(8'h00, d); chk("R4 force zero after wake", d, 32'h0);
    wr(8'h14, 32'h0, 4'b0010);
    rd(8'h14, d); chk("R7 write 0 keeps flag", d, 32'h0000_0101);
    wr(8'h14, 32'h100, 4'b0010);
    rd(8'h14, d); chk("R7 write 1 clears flag", d, 32'h0000_0001);
    wakePinIn[0] = 1'b0;
    idle(4);
    rd(8'h14, d); chk("R7 level follows pin", d, 32'h0);
  endtask

  task automatic test_active_edge();
    logic [31:0] d;
    wakePinIn[0] = 1'b1;
    idle(5);
    rd(8'h14, d); chk("R11 no cause while active", d, 32'h0000_0001);
    rd(8'h04, d); chk("R11 still active", d, 32'h0);
    wakePinIn[0] = 1'b0;
    idle(4);
  endtask

  task automatic test_light();
    logic [31:0] d;
    int n;
    wr(8'h08, 32'h4, 4'b0001);
    wakePinIn[2] = 1'b1;
    idle(4);
    wr(8'h00, 32'h5, 4'b0001);
    waitOff(n);
    chk("R3 entry light", 32'(n), 32'(ENTER_CYCLES));
    chk("R8 light not deep", 32'(deepSleepOut), 32'd0);
    idle(8);
    chk("R5 static pin no wake", 32'(pwrOnOut), 32'd0);
    wakePinIn[2] = 1'b0;
    idle(4);
    chk("R5 falling edge no wake", 32'(pwrOnOut), 32'd0);
    wakePinIn[2] = 1'b1;
    idle(4);
    chk("R5 enabled edge wakes", 32'(pwrOnOut), 32'd1);
    idle(WAKE_CYCLES + 10);
    chk("R4 no re-entry", 32'(pwrOnOut), 32'd1);
    rd(8'h04, d); chk("R4 active after wake", d, 32'h0);
    rd(8'h14, d); chk("R7 cause pin2", d, 32'h0000_0404);
    wakePinIn[2] = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    test_reset();
    test_regs();
    test_enter_deep();
    test_disabled_pin();
    test_force_in_sleep();
    test_wake();
    test_active_edge();
    test_light();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule